// File: doc/BRIEF.md
# Peripheral-Paced Byte DMA Channel

This block is one DMA channel that copies a run of bytes from RAM to a single, fixed peripheral data register. Software programs the peripheral register address, the RAM start address and the byte count. It then sets the channel enable and the start bit, and writes a software trigger to launch the first byte. The peripheral then paces the rest: each transfer-done pulse on `periphTrig` launches the next byte. When the last byte has been written into the peripheral register, the start bit clears itself and a one-cycle completion interrupt is raised. The interrupt does not wait for the peripheral to finish sending that byte.

Each transfer is a RAM read followed in the next cycle by a write of the returned byte to the peripheral address. The memory port is a simple request port with no wait states. Read data is returned one cycle after the read request. The enable bit is locked while start is 1. To stop a sequence early, software clears start and then clears enable.

Top module: `periph_dma_channel`

## Requirements
- R1: After reset, all four registers read 0, `dmaIrq` is 0 and `memReq` is 0.
- R2: The register map uses word offsets on `regAddr`: 0 = control, 1 = peripheral address, 2 = RAM address, 3 = remaining byte count. The control bits are: bit 0 enable, bit 1 start, bit 2 software trigger, bit 3 hold-RAM mode.
- R3: A control write changes the enable bit only while start is 0. While start is 1, the written enable value is ignored and enable reads back unchanged.
- R4: The software trigger bit is write-one and always reads back 0. It launches a transfer only when enable and start are both 1; otherwise it causes no memory access.
- R5: A transfer reads RAM at the RAM address (`memReq`=1, `memWe`=0). In the next cycle it writes the returned byte to the peripheral address (`memReq`=1, `memWe`=1). The peripheral address register is never changed by a transfer.
- R6: After each transfer, the byte count decrements by one. The RAM address increments by one, or stays put when hold-RAM mode (control bit 3) is 1.
- R7: After the first byte, a transfer starts only on a `periphTrig` pulse. With no trigger, no memory access takes place.
- R8: On the write of the final byte, the start bit clears. `dmaIrq` is high for exactly the one cycle that follows that write.
- R9: A byte count programmed as 0 means 65536 transfers. After one transfer it reads 0xFFFF and start stays 1.
- R10: Clearing start stops the channel: no memory access follows, and later triggers are ignored. With start at 0, enable can then be cleared.
- R11: A trigger that arrives while a transfer is in flight is held as one pending request and is serviced right after that transfer. Several such triggers collapse into one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word offset |
| regWData | input | 16 | Register write data |
| regRData | output | 16 | Register read data for `regAddr` |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Memory access address |
| memWData | output | 8 | Byte written to the peripheral register |
| memRData | input | 8 | Read data, valid the cycle after a read request |
| periphTrig | input | 1 | Peripheral transfer-done pulse |
| dmaIrq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check the following on every cycle:
- a locked enable keeps its value under a control write;
- every peripheral write directly follows a RAM read;
- a transfer steps the count down by exactly one and moves the RAM address according to the mode;
- the final write drops start and raises the interrupt;
- no read begins in the cycle after the channel was inactive.

Other behaviours need whole scenarios from the bench:
- the byte stream reaching the peripheral matches RAM in order;
- triggers that arrive during a transfer collapse into a single extra transfer;
- a zero count runs past the 16-bit wrap;
- forced termination issues nothing further, even when it lands in the same cycle as a launch.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] OFF_PADDR = 2'd1;
  localparam logic [REG_AW-1:0] OFF_RADDR = 2'd2;
  localparam logic [REG_AW-1:0] OFF_COUNT = 2'd3;

  localparam int BIT_EN     = 0;
  localparam int BIT_START  = 1;
  localparam int BIT_SWTRIG = 2;
  localparam int BIT_HOLD   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic rdReq;
    logic wrReq;
    logic step;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WRITE = 2'd2
  } chState_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  input  logic              periphTrig,
  input  logic              lastByte,
  output dpStrobe_t         stb,
  output logic              enable,
  output logic              start,
  output logic              dmaIrq
);
  chState_t state;
  logic     pending;
  logic     ctrlWr;
  logic     active;
  logic     trigIn;
  logic     launch;
  logic     finish;

  assign ctrlWr = regWr && (regAddr == OFF_CTRL);
  assign active = enable && start;
  assign trigIn = active && (periphTrig || (ctrlWr && regWData[BIT_SWTRIG]));
  assign launch = (state == S_IDLE) && active && pending;

  always_comb begin
    stb       = '0;
    stb.rdReq = (state == S_READ) && active;
    stb.wrReq = (state == S_WRITE) && active;
    stb.step  = stb.wrReq;
  end

  assign finish = stb.wrReq && lastByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pending <= 1'b0;
      enable  <= 1'b0;
      start   <= 1'b0;
      dmaIrq  <= 1'b0;
    end else begin
      dmaIrq <= finish;

      case (state)
        S_IDLE:  if (launch) state <= S_READ;
        S_READ:  state <= active ? S_WRITE : S_IDLE;
        default: state <= S_IDLE;
      endcase

      // one pending slot; a new trigger outranks the launch that consumes it
      if (!active)     pending <= 1'b0;
      else if (trigIn) pending <= 1'b1;
      else if (launch) pending <= 1'b0;

      if (ctrlWr) begin
        if (!start) enable <= regWData[BIT_EN];
        start <= regWData[BIT_START];
      end else if (finish) begin
        start <= 1'b0;
      end
    end
  end

  // R3: enable is locked while start is set
  a_r3_enable_locked: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && start) |=> (enable == $past(enable)));

  // R5: every peripheral write directly follows a RAM read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrReq |-> $past(stb.rdReq));

  // R8: final byte drops start and raises the interrupt
  a_r8_final_stops: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrReq && lastByte && !ctrlWr) |=> (!start && dmaIrq));

  // R10: no read can begin right after the channel was inactive
  a_r10_stop_quiets_bus: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !stb.rdReq);
endmodule

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  input  dpStrobe_t         stb,
  input  logic              enable,
  input  logic              start,
  output logic              lastByte,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] periphAddr;
  logic [ADDR_W-1:0] ramAddr;
  logic [CNT_W-1:0]  byteCount;
  logic              holdRam;

  logic ctrlWr, paddrWr, raddrWr, countWr;

  assign ctrlWr  = regWr && (regAddr == OFF_CTRL);
  assign paddrWr = regWr && (regAddr == OFF_PADDR);
  assign raddrWr = regWr && (regAddr == OFF_RADDR);
  assign countWr = regWr && (regAddr == OFF_COUNT);

  assign lastByte = (byteCount == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periphAddr <= '0;
      ramAddr    <= '0;
      byteCount  <= '0;
      holdRam    <= 1'b0;
    end else begin
      if (stb.step) begin
        if (!holdRam) ramAddr <= ramAddr + ADDR_W'(1);
        byteCount <= byteCount - CNT_ONE;
      end
      if (ctrlWr)  holdRam    <= regWData[BIT_HOLD];
      if (paddrWr) periphAddr <= regWData[ADDR_W-1:0];
      if (raddrWr) ramAddr    <= regWData[ADDR_W-1:0];
      if (countWr) byteCount  <= regWData[CNT_W-1:0];
    end
  end

  assign memReq   = stb.rdReq || stb.wrReq;
  assign memWe    = stb.wrReq;
  assign memAddr  = stb.wrReq ? periphAddr : ramAddr;
  assign memWData = memRData;

  always_comb begin
    regRData = '0;
    case (regAddr)
      OFF_CTRL: begin
        regRData[BIT_EN]    = enable;
        regRData[BIT_START] = start;
        regRData[BIT_HOLD]  = holdRam;
      end
      OFF_PADDR: regRData[ADDR_W-1:0] = periphAddr;
      OFF_RADDR: regRData[ADDR_W-1:0] = ramAddr;
      default:   regRData[CNT_W-1:0]  = byteCount;
    endcase
  end

  // R6: a transfer takes exactly one from the count
  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !countWr) |=> (byteCount == $past(byteCount) - CNT_ONE));

  // R6: RAM address advances only outside hold mode
  a_r6_ram_advance: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !raddrWr && !ctrlWr) |=>
      (ramAddr == $past(ramAddr) + ($past(holdRam) ? ADDR_W'(0) : ADDR_W'(1))));

  // R5: the peripheral address survives transfers
  a_r5_paddr_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !paddrWr) |=> $stable(periphAddr));
endmodule

// File: rtl/periph_dma_channel.sv
module periph_dma_channel
  import dma_chan_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  input  logic              periphTrig,
  output logic              dmaIrq
);
  dpStrobe_t stb;
  logic      enable;
  logic      start;
  logic      lastByte;

  dma_chan_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .periphTrig(periphTrig), .lastByte(lastByte),
    .stb(stb), .enable(enable), .start(start), .dmaIrq(dmaIrq)
  );

  dma_chan_datapath #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .stb(stb),
    .enable(enable), .start(start), .lastByte(lastByte),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData)
  );
endmodule

// File: tb/tb_periph_dma_channel.sv
module tb_periph_dma_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWData = '0;
  logic [15:0] regRData;
  logic        memReq, memWe;
  logic [15:0] memAddr;
  logic [7:0]  memWData;
  logic [7:0]  memRData = '0;
  logic        periphTrig = 1'b0;
  logic        dmaIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  ram [256];
  logic [15:0] expPtr = '0;
  logic [15:0] expPaddr = '0;
  bit          expHold = 0;
  int          expRemain = 0;
  int          writesSeen = 0;
  int          readsSeen = 0;
  int          irqSeen = 0;
  bit          prevRd = 0;
  logic [15:0] prevAddr = '0;
  bit          irqDue = 0;
  bit          curHold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_dma_channel dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .periphTrig(periphTrig), .dmaIrq(dmaIrq)
  );

  // RAM model: read data one cycle after the request
  always @(posedge clk) if (memReq && !memWe) memRData <= ram[memAddr[7:0]];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor and reference model
  always @(negedge clk) begin
    if (rstN) begin
      if (irqDue || dmaIrq) begin
        check(dmaIrq == irqDue, "R8 irq one cycle after final write", dmaIrq, irqDue);
        if (dmaIrq) irqSeen++;
      end
      irqDue = 0;
      if (memReq && memWe) begin
        check(prevRd && prevAddr == expPtr, "R5 read precedes write", prevAddr, expPtr);
        check(memAddr == expPaddr, "R5 write address", memAddr, expPaddr);
        check(memWData == ram[expPtr[7:0]], "R5 write data", memWData, ram[expPtr[7:0]]);
        writesSeen++;
        if (!expHold) expPtr = expPtr + 16'd1;
        expRemain--;
        irqDue = (expRemain == 0);
      end
      if (memReq && !memWe) readsSeen++;
      prevRd   = memReq && !memWe;
      prevAddr = memAddr;
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1 v = regRData;
  endtask

  task automatic pulse();
    periphTrig = 1'b1;
    @(negedge clk);
    periphTrig = 1'b0;
  endtask

  function automatic logic [15:0] ctrlWord(bit hold, bit sw, bit st, bit en);
    return {12'd0, hold, sw, st, en};
  endfunction

  task automatic startRun(input logic [15:0] pa, input logic [15:0] ra,
                          input logic [15:0] cnt, input bit hold);
    regWrite(2'd1, pa);
    regWrite(2'd2, ra);
    regWrite(2'd3, cnt);
    expPaddr = pa; expPtr = ra; expHold = hold; curHold = hold;
    expRemain = (cnt == 0) ? 65536 : int'(cnt);
    regWrite(2'd0, ctrlWord(hold, 0, 0, 1));
    regWrite(2'd0, ctrlWord(hold, 0, 1, 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int w0, r0, i0;
    void'($urandom(32'd20240611));
    foreach (ram[i]) ram[i] = 8'($urandom());

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2: reset state at every register offset
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v);
      check(v == 16'd0, "R1 reset register value", v, 0);
    end
    check(!dmaIrq && !memReq, "R1 idle outputs", {dmaIrq, memReq}, 0);

    // R2 / R4: trigger with enable=1 start=0 does nothing; trigger reads 0
    regWrite(2'd0, ctrlWord(0, 1, 0, 1));
    repeat (4) @(negedge clk);
    check(readsSeen == 0, "R4 trigger without start", readsSeen, 0);
    regRead(2'd0, v);
    check(v == 16'h0001, "R2 R4 control readback", v, 16'h0001);

    // R3: enable=0 with start=1, then locked; trigger ignored
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));
    regWrite(2'd0, ctrlWord(0, 0, 1, 0));
    regWrite(2'd0, ctrlWord(0, 1, 1, 1));
    regRead(2'd0, v);
    check(v[0] == 1'b0, "R3 enable locked low while started", v[0], 0);
    pulse();
    repeat (4) @(negedge clk);
    check(readsSeen == 0, "R4 trigger with enable 0", readsSeen, 0);
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));

    // main run: count 4, sw first, peripheral paces the rest
    startRun(16'h0010, 16'hFB00, 16'd4, 0);
    repeat (5) @(negedge clk);
    check(readsSeen == 0, "R7 no transfer without trigger", readsSeen, 0);
    regWrite(2'd0, ctrlWord(0, 1, 1, 1));
    repeat (5) @(negedge clk);
    check(writesSeen == 1, "R4 software trigger launches one byte", writesSeen, 1);
    regRead(2'd2, v);
    check(v == 16'hFB01, "R6 RAM address incremented", v, 16'hFB01);
    regRead(2'd3, v);
    check(v == 16'd3, "R6 count decremented", v, 3);
    regRead(2'd1, v);
    check(v == 16'h0010, "R5 peripheral address fixed", v, 16'h0010);
    regWrite(2'd0, ctrlWord(0, 0, 1, 0));
    regRead(2'd0, v);
    check(v == 16'h0003, "R3 enable clear ignored while started", v, 16'h0003);
    repeat (6) @(negedge clk);
    check(writesSeen == 1, "R7 waits for peripheral pulse", writesSeen, 1);
    for (int k = 0; k < 3; k++) begin
      pulse();
      repeat (4 + $urandom_range(0, 3)) @(negedge clk);
    end
    check(writesSeen == 4, "R7 peripheral paced transfers", writesSeen, 4);
    check(irqSeen == 1, "R8 one completion interrupt", irqSeen, 1);
    regRead(2'd0, v);
    check(v[1] == 1'b0, "R8 start self-cleared", v[1], 0);
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));

    // R11: triggers during flight collapse to one pending request
    w0 = writesSeen;
    startRun(16'h0020, 16'h0040, 16'd3, 0);
    regWrite(2'd0, ctrlWord(0, 1, 1, 1));
    pulse();
    pulse();
    repeat (10) @(negedge clk);
    check(writesSeen - w0 == 2, "R11 in-flight triggers collapse to one", writesSeen - w0, 2);
    regRead(2'd3, v);
    check(v == 16'd1, "R11 count after pending service", v, 1);
    pulse();
    repeat (6) @(negedge clk);
    check(writesSeen - w0 == 3, "R11 final byte after new pulse", writesSeen - w0, 3);
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));

    // R6: hold-RAM mode
    startRun(16'h0031, 16'h0080, 16'd2, 1);
    regWrite(2'd0, ctrlWord(1, 1, 1, 1));
    repeat (5) @(negedge clk);
    pulse();
    repeat (6) @(negedge clk);
    regRead(2'd2, v);
    check(v == 16'h0080, "R6 hold mode keeps RAM address", v, 16'h0080);
    regRead(2'd0, v);
    check(v == 16'h0009, "R6 hold mode done, start cleared", v, 16'h0009);
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));

    // R9: zero count, then R10 forced termination
    i0 = irqSeen;
    startRun(16'h0044, 16'h0100, 16'd0, 0);
    regWrite(2'd0, ctrlWord(0, 1, 1, 1));
    repeat (5) @(negedge clk);
    regRead(2'd3, v);
    check(v == 16'hFFFF, "R9 zero count wraps to FFFF", v, 16'hFFFF);
    regRead(2'd0, v);
    check(v[1] == 1'b1, "R9 start stays set", v[1], 1);
    w0 = writesSeen; r0 = readsSeen;
    pulse();
    regWrite(2'd0, ctrlWord(0, 0, 0, 1));
    repeat (4) @(negedge clk);
    pulse();
    regWrite(2'd0, ctrlWord(0, 1, 0, 1));
    repeat (6) @(negedge clk);
    check(readsSeen == r0 && writesSeen == w0, "R10 no access after stop", readsSeen - r0, 0);
    regRead(2'd3, v);
    check(v == 16'hFFFF, "R10 count frozen after stop", v, 16'hFFFF);
    check(irqSeen == i0, "R10 no interrupt on forced stop", irqSeen - i0, 0);
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));
    regRead(2'd0, v);
    check(v == 16'h0000, "R10 enable clears once stopped", v, 0);

    // constrained random runs
    for (int it = 0; it < 8; it++) begin
      int cnt;
      cnt = $urandom_range(1, 6);
      w0 = writesSeen; i0 = irqSeen;
      startRun(16'($urandom()), {8'($urandom()), 8'($urandom())}, 16'(cnt), 0);
      regWrite(2'd0, ctrlWord(0, 1, 1, 1));
      repeat (4) @(negedge clk);
      for (int k = 1; k < cnt; k++) begin
        pulse();
        repeat (3 + $urandom_range(0, 4)) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check(writesSeen - w0 == cnt, "R7 random run byte count", writesSeen - w0, cnt);
      check(irqSeen - i0 == 1, "R8 random run interrupt", irqSeen - i0, 1);
      regRead(2'd3, v);
      check(v == 16'd0, "R6 random run count exhausted", v, 0);
      regWrite(2'd0, ctrlWord(0, 0, 0, 0));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule